// File: doc/BRIEF.md
# Pipelined Arbitrated Packet Crossbar

This block switches fixed-width packets from a set of source ports to a set of destination ports. In its default shape it has eight sources and nine destinations. Destinations 0 to 7 are cache banks and destination 8 is the I/O hub. Each source offers one packet at a time, tagged with a binary destination index. The crossbar delivers the packet unchanged on that destination's output.

A packet moves through three stages. In the request stage the packet is captured into a small queue owned by its source. In the arbitration stage each destination picks one waiting head packet with a rotating-priority arbiter and pulses a grant back to the winning source. In the transmit stage the packet sits in the destination's output register until the destination accepts it.

The winner's payload is steered by a tree of 2:1 multiplexers that uses the binary winner index. Contention and backpressure stretch the latency beyond three cycles. Without contention, each destination still accepts one packet every cycle. Port counts, packet width and queue depth are parameters, so the same block also serves the reverse direction (nine sources, eight destinations, 146-bit packets).

Top module: `pkt_xbar`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dst_valid`, `src_stall` and `src_grant` are all zero.
- R2: A packet whose source slice of `src_dest` holds binary index d is delivered only on destination d, with its payload bit-for-bit unchanged. With an idle path, the packet is accepted at clock edge t. `src_grant` for its source is then high in the cycle after t, and `dst_valid[d]` rises in the cycle after that.
- R3: Sources that each target a different destination every cycle see no stall. In steady state every targeted destination presents a valid packet on every cycle.
- R4: Each destination grants round-robin. After a winner w, the search for the next winner starts at source w+1 and wraps modulo the source count. The pointer starts at source 0 after reset.
- R5: While `dst_valid[d]` is high and `dst_ready[d]` is low, the packet on destination d stays valid and its data does not change. During that time no grant is issued for destination d.
- R6: Each source queue holds QDEPTH packets (default 2). `src_stall` is high exactly while the queue is full. A packet presented while stalled is ignored and must be held by the source until the stall drops.
- R7: Packets from one source to one destination are delivered in the order in which they were accepted.
- R8: `src_grant` pulses for one cycle for each packet that wins arbitration. Over any run, the number of grants equals the number of accepted packets once the crossbar has drained.
- R9: The highest destination index (the I/O hub, index 8 by default) behaves exactly like the cache-bank destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | N_SRC | Per source: a packet is offered this cycle |
| src_dest | input | N_SRC*clog2(N_DST) | Per source: binary destination index, source s in slice s |
| src_data | input | N_SRC*PKT_W | Per source: packet payload, source s in slice s |
| src_stall | output | N_SRC | Per source: queue full, offered packet not taken |
| src_grant | output | N_SRC | Per source: one-cycle pulse when its head packet wins |
| dst_valid | output | N_DST | Per destination: output packet valid |
| dst_data | output | N_DST*PKT_W | Per destination: output packet, destination d in slice d |
| dst_ready | input | N_DST | Per destination: packet is taken at this clock edge |

## Verification
Two things can happen to a destination in the same cycle: its output register hands a packet to a ready destination, and its arbiter grants a new winner into that same register. A missed refill shows up as a gap in the output stream. A refill that ignores backpressure overwrites a packet. The bench provokes the overlap with eight sources streaming to eight separate destinations on every cycle, and counts the cycles in which all eight outputs are valid against the exact expected count. A long random phase then toggles each `dst_ready` while queues fill and drain. Every delivered packet carries its source, destination and a per-pair sequence number, which the bench compares with its own counters to catch loss, duplication or reordering.

// File: rtl/pkt_xbar_pkg.sv
package pkt_xbar_pkg;

    // Index that follows idx in a ring of n entries.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/xbar_src_fifo.sv
// Request-stage queue of one source: holds {destination, payload} entries.
module xbar_src_fifo #(
    parameter int W     = 134,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full       = (st_q.cnt == CW'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];

endmodule

// File: rtl/xbar_rr_arb.sv
// Arbitration stage of one destination: rotating priority over the sources.
module xbar_rr_arb
    import pkt_xbar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 en,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] win
);
    localparam int SW = $clog2(N);

    typedef struct packed {
        logic [SW-1:0] ptr;
    } arb_st_t;

    arb_st_t       st_d, st_q;
    logic          found;
    logic [SW-1:0] cand;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        win   = '0;
        found = 1'b0;
        cand  = '0;
        for (int i = 0; i < N; i++) begin
            cand = SW'((int'(st_q.ptr) + i) % N);
            if (!found && en && req[cand]) begin
                found = 1'b1;
                win   = cand;
            end
        end
        if (found) begin
            grant[win] = 1'b1;
            st_d.ptr   = SW'(ring_next(32'(win), N));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/xbar_mux_tree.sv
// Binary tree of 2:1 selectors; leaf index equals sel.
module xbar_mux_tree #(
    parameter int N = 8,
    parameter int W = 130
) (
    input  logic [N*W-1:0]       din,
    input  logic [$clog2(N)-1:0] sel,
    output logic [W-1:0]         dout
);
    localparam int SW = $clog2(N);
    localparam int P  = 1 << SW;

    // Level k holds (P >> k) nodes; level 0 are the leaves, level SW the root.
    for (genvar k = 0; k <= SW; k++) begin : g_lvl
        localparam int NODES = P >> k;
        logic [NODES*W-1:0] node;
        if (k == 0) begin : g_leaf
            for (genvar j = 0; j < P; j++) begin : g_in
                if (j < N) begin : g_real
                    assign node[j*W +: W] = din[j*W +: W];
                end else begin : g_pad
                    assign node[j*W +: W] = '0;
                end
            end
        end else begin : g_mux
            for (genvar j = 0; j < NODES; j++) begin : g_m
                assign node[j*W +: W] = sel[k-1] ? g_lvl[k-1].node[(2*j+1)*W +: W]
                                                 : g_lvl[k-1].node[(2*j)*W +: W];
            end
        end
    end

    assign dout = g_lvl[SW].node;

endmodule

// File: rtl/pkt_xbar.sv
// Three-stage crossbar: source queues, per-destination arbiters, output registers.
module pkt_xbar #(
    parameter int N_SRC  = 8,
    parameter int N_DST  = 9,
    parameter int PKT_W  = 130,
    parameter int QDEPTH = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_SRC-1:0]                 src_valid,
    input  logic [N_SRC*$clog2(N_DST)-1:0]   src_dest,
    input  logic [N_SRC*PKT_W-1:0]           src_data,
    output logic [N_SRC-1:0]                 src_stall,
    output logic [N_SRC-1:0]                 src_grant,
    output logic [N_DST-1:0]                 dst_valid,
    output logic [N_DST*PKT_W-1:0]           dst_data,
    input  logic [N_DST-1:0]                 dst_ready
);
    localparam int DW = $clog2(N_DST);
    localparam int SW = $clog2(N_SRC);
    localparam int EW = DW + PKT_W;

    typedef struct packed {
        logic [N_DST-1:0]            vld;
        logic [N_DST-1:0][PKT_W-1:0] dat;
    } xmit_st_t;

    xmit_st_t xs_d, xs_q;

    logic [N_SRC-1:0]             q_full, q_hvld, q_pop;
    logic [N_SRC-1:0][DW-1:0]     q_hdest;
    logic [N_SRC*PKT_W-1:0]       q_hdata;

    logic [N_DST-1:0][N_SRC-1:0]  req, gnt;
    logic [N_DST-1:0][SW-1:0]     win;
    logic [N_DST-1:0]             take, any_gnt;
    logic [N_DST-1:0][PKT_W-1:0]  pick;

    // Request stage
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        logic [EW-1:0] head;
        xbar_src_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (src_valid[s]),
            .push_data  ({src_dest[s*DW +: DW], src_data[s*PKT_W +: PKT_W]}),
            .pop        (q_pop[s]),
            .full       (q_full[s]),
            .head_valid (q_hvld[s]),
            .head_data  (head)
        );
        assign q_hdest[s]                 = head[EW-1 -: DW];
        assign q_hdata[s*PKT_W +: PKT_W]  = head[PKT_W-1:0];
    end

    // Arbitration stage and selection tree per destination
    for (genvar d = 0; d < N_DST; d++) begin : g_dst
        for (genvar s = 0; s < N_SRC; s++) begin : g_req
            assign req[d][s] = q_hvld[s] && (q_hdest[s] == DW'(d));
        end
        assign take[d] = !xs_q.vld[d] || dst_ready[d];

        xbar_rr_arb #(.N(N_SRC)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[d]),
            .en    (take[d]),
            .grant (gnt[d]),
            .win   (win[d])
        );

        xbar_mux_tree #(.N(N_SRC), .W(PKT_W)) u_mux (
            .din  (q_hdata),
            .sel  (win[d]),
            .dout (pick[d])
        );

        assign any_gnt[d]                 = |gnt[d];
        assign dst_data[d*PKT_W +: PKT_W] = xs_q.dat[d];
    end

    // A source heads toward one destination, so at most one grant reaches it.
    always_comb begin
        q_pop = '0;
        for (int d = 0; d < N_DST; d++) begin
            q_pop = q_pop | gnt[d];
        end
    end

    // Transmit stage
    always_comb begin
        xs_d = xs_q;
        for (int d = 0; d < N_DST; d++) begin
            if (take[d]) begin
                xs_d.vld[d] = any_gnt[d];
                if (any_gnt[d]) begin
                    xs_d.dat[d] = pick[d];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs_q <= '0;
        end else begin
            xs_q <= xs_d;
        end
    end

    assign src_stall = q_full;
    assign src_grant = q_pop;
    assign dst_valid = xs_q.vld;

endmodule

// File: rtl/pkt_xbar_chk.sv
module pkt_xbar_chk #(
    parameter int N_SRC = 8,
    parameter int N_DST = 9,
    parameter int PKT_W = 130
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_SRC-1:0]         src_valid,
    input logic [N_SRC-1:0]         src_stall,
    input logic [N_SRC-1:0]         src_grant,
    input logic [N_DST-1:0]         dst_valid,
    input logic [N_DST*PKT_W-1:0]   dst_data,
    input logic [N_DST-1:0]         dst_ready
);
    for (genvar d = 0; d < N_DST; d++) begin : g_d
        // R5: a refused output packet is held unchanged
        a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
            dst_valid[d] && !dst_ready[d] |=> dst_valid[d] && $stable(dst_data[d*PKT_W +: PKT_W]));
        // R2: an output only becomes valid after a grant in the previous cycle
        a_r2_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dst_valid[d]) |-> $past(|src_grant));
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_s
        // R6: a full queue stays full until one of its packets wins
        a_r6_stall_persists: assert property (@(posedge clk) disable iff (!rst_n)
            src_stall[s] && !src_grant[s] |=> src_stall[s]);
        // R6: a queue fills only through an offered packet
        a_r6_stall_from_push: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_stall[s]) |-> $past(src_valid[s]));
    end

endmodule

bind pkt_xbar pkt_xbar_chk #(.N_SRC(N_SRC), .N_DST(N_DST), .PKT_W(PKT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_stall (src_stall),
    .src_grant (src_grant),
    .dst_valid (dst_valid),
    .dst_data  (dst_data),
    .dst_ready (dst_ready)
);

// File: tb/pkt_xbar_test.sv
module pkt_xbar_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int ND = 9;
    localparam int W  = 130;
    localparam int DW = 4;
    localparam int WDOG = 150000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NS-1:0]      src_valid;
    logic [NS*DW-1:0]   src_dest;
    logic [NS*W-1:0]    src_data;
    logic [NS-1:0]      src_stall;
    logic [NS-1:0]      src_grant;
    logic [ND-1:0]      dst_valid;
    logic [ND*W-1:0]    dst_data;
    logic [ND-1:0]      dst_ready;

    int n_chk = 0;
    int n_err = 0;
    int nxt_seq [NS][ND];
    int exp_seq [NS][ND];
    int acc_cnt [NS];
    logic [NS-1:0] acc;
    int sent_tot = 0, recv_tot = 0, gnt_tot = 0;
    int log_dst = 15;
    int log_n = 0;
    int log_buf [16];

    pkt_xbar uut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
        .src_data(src_data), .src_stall(src_stall), .src_grant(src_grant),
        .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // Payload tag: [3:0] destination, [7:4] source, [23:8] sequence, rest random.
    task automatic offer(input int s, input int d);
        logic [W-1:0] p;
        for (int k = 0; k < W; k++) p[k] = 1'($urandom);
        p[3:0]  = 4'(d);
        p[7:4]  = 4'(s);
        p[23:8] = 16'(nxt_seq[s][d]);
        nxt_seq[s][d]++;
        src_valid[s] = 1'b1;
        src_dest[s*DW +: DW] = DW'(d);
        src_data[s*W +: W] = p;
    endtask

    task automatic tick();
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            if (acc[s]) begin
                src_valid[s] = 1'b0;
                acc[s] = 1'b0;
            end
        end
    endtask

    // Monitor: samples just before each rising edge.
    always @(negedge clk) begin
        #(CLK_PERIOD/2 - 1);
        if (rst_n) begin
            for (int s = 0; s < NS; s++) begin
                if (src_valid[s] && !src_stall[s]) begin
                    acc[s] = 1'b1;
                    acc_cnt[s]++;
                    sent_tot++;
                end
                if (src_grant[s]) gnt_tot++;
            end
            for (int d = 0; d < ND; d++) begin
                if (dst_valid[d] && dst_ready[d]) begin
                    logic [W-1:0] pk;
                    int ps;
                    pk = dst_data[d*W +: W];
                    ps = int'(pk[7:4]);
                    check(int'(pk[3:0]) == d, "R2 packet on wrong destination", pk[3:0], d);
                    if (ps < NS) begin
                        check(pk[23:8] == 16'(exp_seq[ps][d]), "R7 sequence order", pk[23:8], exp_seq[ps][d]);
                        exp_seq[ps][d]++;
                    end else begin
                        check(1'b0, "R2 source tag out of range", ps, 0);
                    end
                    recv_tot++;
                    if (d == log_dst && log_n < 16) begin
                        log_buf[log_n] = ps;
                        log_n++;
                    end
                end
            end
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1..: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        int full_cnt;
        bit stall_seen;
        logic [W-1:0] held;
        void'($urandom(32'd4242));
        for (int s = 0; s < NS; s++) begin
            acc_cnt[s] = 0;
            for (int d = 0; d < ND; d++) begin
                nxt_seq[s][d] = 0;
                exp_seq[s][d] = 0;
            end
        end
        acc = '0;
        rst_n = 1'b0;
        src_valid = '0;
        src_dest = '0;
        src_data = '0;
        dst_ready = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(dst_valid == '0, "R1 dst_valid in reset", dst_valid, 0);
        check(src_stall == '0 && src_grant == '0, "R1 stall/grant in reset", {src_stall, src_grant}, 0);
        rst_n = 1'b1;
        tick();
        check(dst_valid == '0 && src_stall == '0 && src_grant == '0, "R1 first cycle after reset",
              {dst_valid, src_stall, src_grant}, 0);

        // R2 / R8: minimum latency, single grant pulse
        offer(3, 5);
        tick(); #2;
        check(src_grant == 8'h08, "R2 grant one cycle after accept", src_grant, 8'h08);
        check(dst_valid[5] == 1'b0, "R2 output not yet valid", dst_valid[5], 0);
        tick(); #2;
        check(dst_valid[5] == 1'b1, "R2 output valid two cycles after accept", dst_valid[5], 1);
        check(src_grant == '0, "R8 grant is a single pulse", src_grant, 0);
        repeat (2) tick();

        // R9: I/O hub destination
        offer(7, 8);
        tick(); tick(); #2;
        check(dst_valid[8] == 1'b1 && dst_data[8*W+4 +: 4] == 4'd7, "R9 hub destination delivery",
              {dst_valid[8], dst_data[8*W+4 +: 4]}, {1'b1, 4'd7});
        repeat (2) tick();

        // R5: backpressure holds the output
        dst_ready[4] = 1'b0;
        offer(1, 4);
        repeat (3) tick();
        #2;
        held = dst_data[4*W +: W];
        for (int k = 0; k < 3; k++) begin
            tick(); #2;
            check(dst_valid[4] == 1'b1 && dst_data[4*W +: W] == held, "R5 output held under backpressure",
                  dst_valid[4], 1);
        end
        dst_ready[4] = 1'b1;
        tick(); #2;
        check(dst_valid[4] == 1'b0, "R5 output drained after ready", dst_valid[4], 0);

        // R6 / R7: queue fills, stall holds the next packet, order kept
        dst_ready[0] = 1'b0;
        base = acc_cnt[0];
        begin
            int n = 0;
            for (int k = 0; k < 8; k++) begin
                tick();
                if (!src_valid[0] && n < 4) begin
                    offer(0, 0);
                    n++;
                end
            end
        end
        #2;
        check(src_stall[0] == 1'b1, "R6 stall when queue full", src_stall[0], 1);
        check(acc_cnt[0] - base == 3, "R6 packet ignored while stalled", acc_cnt[0] - base, 3);
        dst_ready[0] = 1'b1;
        repeat (12) tick();
        check(exp_seq[0][0] == 4, "R7 all four packets delivered in order", exp_seq[0][0], 4);

        // R4: round-robin from pointer 0
        log_dst = 2;
        log_n = 0;
        tick();
        for (int s = 0; s < NS; s++) offer(s, 2);
        repeat (14) tick();
        check(log_n == 8, "R4 burst delivery count", log_n, 8);
        for (int i = 0; i < 8; i++) check(log_buf[i] == i, "R4 burst grant order", log_buf[i], i);
        log_n = 0;
        offer(6, 2);
        repeat (4) tick();
        offer(3, 2);
        offer(7, 2);
        repeat (6) tick();
        check(log_n == 3 && log_buf[1] == 7 && log_buf[2] == 3, "R4 pointer after winner 6 favours 7",
              log_buf[1], 7);
        log_dst = 15;

        // R3: eight sources to eight separate destinations every cycle
        full_cnt = 0;
        stall_seen = 1'b0;
        for (int k = 0; k < 28; k++) begin
            tick();
            if (k < 24) for (int s = 0; s < NS; s++) offer(s, s);
            #2;
            if (|src_stall) stall_seen = 1'b1;
            if (dst_valid[7:0] == 8'hff) full_cnt++;
        end
        check(!stall_seen, "R3 no stall without contention", stall_seen, 0);
        check(full_cnt == 24, "R3 full-throughput cycles", full_cnt, 24);

        // Random traffic with random backpressure
        for (int k = 0; k < 3000; k++) begin
            tick();
            for (int s = 0; s < NS; s++)
                if (!src_valid[s] && ($urandom % 3) == 0) offer(s, int'($urandom % ND));
            for (int d = 0; d < ND; d++) dst_ready[d] = (($urandom % 4) != 0);
        end
        tick();
        dst_ready = '1;
        repeat (60) tick();
        check(src_valid == '0, "R6 held offers eventually accepted", src_valid, 0);
        check(recv_tot == sent_tot, "R7 every accepted packet delivered", recv_tot, sent_tot);
        check(gnt_tot == sent_tot, "R8 grants equal accepted packets", gnt_tot, sent_tot);
        check(dst_valid == '0, "R8 crossbar drained", dst_valid, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule